// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for a display pipe. A horizontal counter steps once per character clock, where one character is eight pixels. A vertical counter steps once per scan line, or once per two scan lines when double scan is on. Programmable compare values turn these counts into horizontal and vertical sync, blanking and a display-enable window. The current character column and row are also brought out, so a downstream memory address counter can use them together with the frame start address and the row offset produced here.

All timing values sit in a bank of eight-bit registers. Software reaches them through an index/data pair: it first writes an index, then writes data to the selected register. Totals are stored with a bias (character total minus 5, line total minus 2). The vertical values are ten bits wide; their top two bits live in a shared overflow register. The end points of sync and blank pulses are short fields that are matched against the low bits of the running count. A protect bit can lock the horizontal registers, the vertical total and the overflow register against writes. The frame start address is only taken up when vertical sync begins, which keeps a page flip away from the visible part of the frame.

Top module: `crtc_timing_top`

## Requirements
- R1: While reset is high and in the cycle after, col_o and row_o are 0, hsync_o, vsync_o and blank_o are 0, de_o is 1, start_addr_o and row_offset_o are 0, and every register reads as zero.
- R2: col_o steps by one each clock from 0 up to HT+4, where HT is register 0, and then returns to 0. A line is therefore HT+5 characters long.
- R3: row_o advances when col_o wraps and counts from 0 up to VT+1 before returning to 0. VT is ten bits: register 6 gives the low byte, overflow register 7 bit 0 gives bit 8, and register 7 bit 5 gives bit 9.
- R4: The internal hsync and hblank states change in the same cycle as col_o. A state becomes active when col_o equals its start (hsync register 4, hblank register 2). It becomes inactive in the first later cycle where col_o[4:0] equals its 5-bit end (hsync register 5 bits 4:0, hblank register 3 bits 4:0).
- R5: The vsync and vblank states change in the same cycle as row_o. vsync starts at the row equal to VS and ends at the first later row whose low 4 bits equal register 12 bits 3:0. VS is register 11 with bit 8 from register 7 bit 2 and bit 9 from register 7 bit 7. vblank starts at VB and ends at the first later row whose low 8 bits equal register 10. VB is register 9 with bit 8 from register 7 bit 3 and bit 9 from register 7 bit 4.
- R6: blank_o is the OR of hblank and vblank. de_o is 1 when col_o is at most register 1 and row_o is at most VD. VD is register 8 with bit 8 from register 7 bit 1 and bit 9 from register 7 bit 6.
- R7: When register 13 bit 7 is set, each row value is held for two consecutive lines.
- R8: Register 17 bit 0 inverts hsync_o and bit 1 inverts vsync_o, making them active-low. When the bit is clear, the output is high while sync is active.
- R9: While register 12 bit 7 is set, data writes to registers 0 to 7 are dropped.
- R10: start_addr_o takes {register 14, register 15} one cycle after vsync becomes active and holds it at all other times. row_offset_o shows register 16 directly.
- R11: A sync start that the counter never reaches, such as 0xFF with a short line or frame, produces no sync pulse at all.
- R12: A cycle with idx_wr high loads wdata into the index. A cycle with dat_wr high writes wdata into the register selected by the index. Index values of 18 and above select no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Character clock |
| rst_i | input | 1 | Synchronous active-high reset |
| idx_wr_i | input | 1 | Load the register index from wdata_i |
| dat_wr_i | input | 1 | Write wdata_i to the indexed register |
| wdata_i | input | 8 | Index or register data |
| hsync_o | output | 1 | Horizontal sync, polarity per control bit 0 |
| vsync_o | output | 1 | Vertical sync, polarity per control bit 1 |
| blank_o | output | 1 | Horizontal or vertical blanking |
| de_o | output | 1 | Display enable window |
| col_o | output | 9 | Character column count |
| row_o | output | 10 | Row count |
| start_addr_o | output | 16 | Frame start address, updated at vsync onset |
| row_offset_o | output | 8 | Row offset for the address counter |

## Verification
A fixed nominal timing is used to pin exact pulse widths and window counts per frame. This separates off-by-one faults in the total bias, the start compare and the low-bit end match. Directed cases then cover a start value beyond the count range, the protect bit, double scan, a ten-bit total that uses the overflow bits, an index outside the bank, and the start address latch. Constrained random timings, with random protect, polarity and double scan, are compared cycle by cycle against a bench model built from the requirements. These expose faults that only appear when start and end values wrap or overlap.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

    localparam int REG_W      = 8;
    localparam int NUM_REGS   = 18;
    localparam int IDX_W      = 5;
    localparam int COL_W      = REG_W + 1;
    localparam int ROW_W      = REG_W + 2;
    localparam int HEND_W     = 5;
    localparam int VEND_W     = 4;
    localparam int VBEND_W    = REG_W;
    localparam int ADDR_W     = 2 * REG_W;
    localparam int PROT_LIMIT = 8;
    localparam int HTOT_BIAS  = 5;
    localparam int VTOT_BIAS  = 2;

    typedef enum logic [IDX_W-1:0] {
        IX_HTOT  = 5'd0,
        IX_HDE   = 5'd1,
        IX_HBS   = 5'd2,
        IX_HBE   = 5'd3,
        IX_HSS   = 5'd4,
        IX_HSE   = 5'd5,
        IX_VTOT  = 5'd6,
        IX_OVF   = 5'd7,
        IX_VDE   = 5'd8,
        IX_VBS   = 5'd9,
        IX_VBE   = 5'd10,
        IX_VSS   = 5'd11,
        IX_VSE   = 5'd12,
        IX_SCAN  = 5'd13,
        IX_STHI  = 5'd14,
        IX_STLO  = 5'd15,
        IX_OFS   = 5'd16,
        IX_CTRL  = 5'd17
    } reg_idx_e;

    typedef enum logic {
        SCAN_FIRST  = 1'b0,
        SCAN_REPEAT = 1'b1
    } scan_phase_e;

    typedef struct packed {
        logic [REG_W-1:0]  htot;
        logic [REG_W-1:0]  hde;
        logic [REG_W-1:0]  hbs;
        logic [HEND_W-1:0] hbe;
        logic [REG_W-1:0]  hss;
        logic [HEND_W-1:0] hse;
    } htiming_t;

    typedef struct packed {
        logic [ROW_W-1:0]   vtot;
        logic [ROW_W-1:0]   vde;
        logic [ROW_W-1:0]   vbs;
        logic [VBEND_W-1:0] vbe;
        logic [ROW_W-1:0]   vss;
        logic [VEND_W-1:0]  vse;
        logic               dbl;
    } vtiming_t;

    typedef struct packed {
        logic              hs_inv;
        logic              vs_inv;
        logic [ADDR_W-1:0] start;
        logic [REG_W-1:0]  offset;
    } misc_t;

    // Pulse state step: an active pulse ends on its end match,
    // an idle one begins on its start match.
    function automatic logic pulse_next(input logic cur,
                                        input logic start_hit,
                                        input logic end_hit);
        return cur ? !end_hit : start_hit;
    endfunction

endpackage

// File: rtl/crtc_regs.sv
module crtc_regs
    import crtc_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             idx_wr_i,
    input  logic             dat_wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output htiming_t         ht_o,
    output vtiming_t         vt_o,
    output misc_t            misc_o
);

    logic [IDX_W-1:0]                idx_q;
    logic [NUM_REGS-1:0][REG_W-1:0]  bank_q;
    logic                            prot;
    logic                            wr_ok;
    logic [REG_W-1:0]                ovf;

    assign prot  = bank_q[int'(IX_VSE)][REG_W-1];
    assign wr_ok = dat_wr_i && (int'(idx_q) < NUM_REGS) &&
                   !((int'(idx_q) < PROT_LIMIT) && prot);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            idx_q  <= '0;
            bank_q <= '0;
        end else begin
            if (idx_wr_i)
                idx_q <= wdata_i[IDX_W-1:0];
            if (wr_ok)
                bank_q[idx_q] <= wdata_i;
        end
    end

    assign ovf = bank_q[int'(IX_OVF)];

    always_comb begin
        ht_o.htot = bank_q[int'(IX_HTOT)];
        ht_o.hde  = bank_q[int'(IX_HDE)];
        ht_o.hbs  = bank_q[int'(IX_HBS)];
        ht_o.hbe  = bank_q[int'(IX_HBE)][HEND_W-1:0];
        ht_o.hss  = bank_q[int'(IX_HSS)];
        ht_o.hse  = bank_q[int'(IX_HSE)][HEND_W-1:0];

        vt_o.vtot = {ovf[5], ovf[0], bank_q[int'(IX_VTOT)]};
        vt_o.vde  = {ovf[6], ovf[1], bank_q[int'(IX_VDE)]};
        vt_o.vbs  = {ovf[4], ovf[3], bank_q[int'(IX_VBS)]};
        vt_o.vbe  = bank_q[int'(IX_VBE)];
        vt_o.vss  = {ovf[7], ovf[2], bank_q[int'(IX_VSS)]};
        vt_o.vse  = bank_q[int'(IX_VSE)][VEND_W-1:0];
        vt_o.dbl  = bank_q[int'(IX_SCAN)][REG_W-1];

        misc_o.hs_inv = bank_q[int'(IX_CTRL)][0];
        misc_o.vs_inv = bank_q[int'(IX_CTRL)][1];
        misc_o.start  = {bank_q[int'(IX_STHI)], bank_q[int'(IX_STLO)]};
        misc_o.offset = bank_q[int'(IX_OFS)];
    end

    // R9: protected timing words keep their value across a blocked write
    assert_protect_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (dat_wr_i && (int'(idx_q) < PROT_LIMIT) && prot)
        |=> $stable(bank_q[PROT_LIMIT-1:0]));

endmodule

// File: rtl/crtc_hcount.sv
module crtc_hcount
    import crtc_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  htiming_t         ht_i,
    output logic [COL_W-1:0] col_o,
    output logic             line_end_o,
    output logic             hs_o,
    output logic             hb_o
);

    logic [COL_W-1:0] col_q;
    logic [COL_W-1:0] col_nxt;
    logic [COL_W-1:0] col_lim;
    logic             hs_q;
    logic             hb_q;

    assign col_lim    = {1'b0, ht_i.htot} + COL_W'(HTOT_BIAS - 1);
    assign line_end_o = (col_q >= col_lim);
    assign col_nxt    = line_end_o ? '0 : col_q + COL_W'(1);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            col_q <= '0;
            hs_q  <= 1'b0;
            hb_q  <= 1'b0;
        end else begin
            col_q <= col_nxt;
            hs_q  <= pulse_next(hs_q, col_nxt == {1'b0, ht_i.hss},
                                col_nxt[HEND_W-1:0] == ht_i.hse);
            hb_q  <= pulse_next(hb_q, col_nxt == {1'b0, ht_i.hbs},
                                col_nxt[HEND_W-1:0] == ht_i.hbe);
        end
    end

    assign col_o = col_q;
    assign hs_o  = hs_q;
    assign hb_o  = hb_q;

    // R2: inside a line the column moves forward by exactly one
    assert_col_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !line_end_o |=> (col_q == $past(col_q) + COL_W'(1)));

endmodule

// File: rtl/crtc_vcount.sv
module crtc_vcount
    import crtc_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             line_end_i,
    input  vtiming_t         vt_i,
    output logic [ROW_W-1:0] row_o,
    output logic             vs_o,
    output logic             vb_o
);

    localparam int RL_W = ROW_W + 1;

    scan_phase_e      phase_q;
    logic [ROW_W-1:0] row_q;
    logic [ROW_W-1:0] row_nxt;
    logic [RL_W-1:0]  row_lim;
    logic             row_adv;
    logic             vs_q;
    logic             vb_q;

    assign row_lim = {1'b0, vt_i.vtot} + RL_W'(VTOT_BIAS - 1);
    assign row_adv = line_end_i && (!vt_i.dbl || phase_q == SCAN_REPEAT);
    assign row_nxt = ({1'b0, row_q} >= row_lim) ? '0 : row_q + ROW_W'(1);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q <= SCAN_FIRST;
            row_q   <= '0;
            vs_q    <= 1'b0;
            vb_q    <= 1'b0;
        end else begin
            if (line_end_i)
                phase_q <= (vt_i.dbl && phase_q == SCAN_FIRST) ? SCAN_REPEAT : SCAN_FIRST;
            if (row_adv) begin
                row_q <= row_nxt;
                vs_q  <= pulse_next(vs_q, row_nxt == vt_i.vss,
                                    row_nxt[VEND_W-1:0] == vt_i.vse);
                vb_q  <= pulse_next(vb_q, row_nxt == vt_i.vbs,
                                    row_nxt[VBEND_W-1:0] == vt_i.vbe);
            end
        end
    end

    assign row_o = row_q;
    assign vs_o  = vs_q;
    assign vb_o  = vb_q;

    // R3: the row only moves at the end of a line
    assert_row_hold_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        !line_end_i |=> $stable(row_q));

    // R5: vertical pulse states only change together with the row
    assert_vflags_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        !line_end_i |=> ($stable(vs_q) && $stable(vb_q)));

endmodule

// File: rtl/crtc_timing_top.sv
module crtc_timing_top
    import crtc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              idx_wr_i,
    input  logic              dat_wr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              blank_o,
    output logic              de_o,
    output logic [COL_W-1:0]  col_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [ADDR_W-1:0] start_addr_o,
    output logic [REG_W-1:0]  row_offset_o
);

    htiming_t          ht;
    vtiming_t          vt;
    misc_t             misc;
    logic [COL_W-1:0]  col;
    logic [ROW_W-1:0]  row;
    logic              line_end;
    logic              hs, hb, vs, vb;
    logic              vs_d_q;
    logic              vs_rise;
    logic [ADDR_W-1:0] start_q;

    crtc_regs u_regs (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .idx_wr_i (idx_wr_i),
        .dat_wr_i (dat_wr_i),
        .wdata_i  (wdata_i),
        .ht_o     (ht),
        .vt_o     (vt),
        .misc_o   (misc)
    );

    crtc_hcount u_hcount (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .ht_i       (ht),
        .col_o      (col),
        .line_end_o (line_end),
        .hs_o       (hs),
        .hb_o       (hb)
    );

    crtc_vcount u_vcount (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .line_end_i (line_end),
        .vt_i       (vt),
        .row_o      (row),
        .vs_o       (vs),
        .vb_o       (vb)
    );

    assign vs_rise = vs && !vs_d_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            vs_d_q  <= 1'b0;
            start_q <= '0;
        end else begin
            vs_d_q <= vs;
            if (vs_rise)
                start_q <= misc.start;
        end
    end

    assign hsync_o      = hs ^ misc.hs_inv;
    assign vsync_o      = vs ^ misc.vs_inv;
    assign blank_o      = hb | vb;
    assign de_o         = (col <= {1'b0, ht.hde}) && (row <= vt.vde);
    assign col_o        = col;
    assign row_o        = row;
    assign start_addr_o = start_q;
    assign row_offset_o = misc.offset;

    // R10: the start address is taken up right after vsync begins
    assert_start_latch_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        vs_rise |=> (start_q == $past(misc.start)));

    // R10: outside that moment the start address holds
    assert_start_hold_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        !vs_rise |=> $stable(start_q));

endmodule

// File: tb/test_crtc_timing_top.sv
`timescale 1ns/100ps
module test_crtc_timing_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        idx_wr = 1'b0;
    logic        dat_wr = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic        hsync_o, vsync_o, blank_o, de_o;
    logic [8:0]  col_o;
    logic [9:0]  row_o;
    logic [15:0] start_addr_o;
    logic [7:0]  row_offset_o;

    always #2.5 clk = ~clk;

    crtc_timing_top i_crtc_timing_top (
        .clk_i        (clk),
        .rst_i        (rst),
        .idx_wr_i     (idx_wr),
        .dat_wr_i     (dat_wr),
        .wdata_i      (wdata),
        .hsync_o      (hsync_o),
        .vsync_o      (vsync_o),
        .blank_o      (blank_o),
        .de_o         (de_o),
        .col_o        (col_o),
        .row_o        (row_o),
        .start_addr_o (start_addr_o),
        .row_offset_o (row_offset_o)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- bench model state ----------------
    logic [7:0] m_regs [18];
    int  m_col, m_row;
    bit  m_hs, m_hb, m_vs, m_vb, m_ph, m_rise;
    int  m_start;
    bit  rst_p;
    bit  pend_v;
    int  pend_idx, pend_dat, m_idx;

    function automatic int ten(input logic [7:0] lo, input bit b8, input bit b9);
        return {22'd0, b9, b8, lo};
    endfunction
    function automatic int f_vtot(); return ten(m_regs[6],  m_regs[7][0], m_regs[7][5]); endfunction
    function automatic int f_vde();  return ten(m_regs[8],  m_regs[7][1], m_regs[7][6]); endfunction
    function automatic int f_vbs();  return ten(m_regs[9],  m_regs[7][3], m_regs[7][4]); endfunction
    function automatic int f_vss();  return ten(m_regs[11], m_regs[7][2], m_regs[7][7]); endfunction

    always @(posedge clk) begin
        rst_p    <= rst;
        pend_v   <= dat_wr && !rst;
        pend_idx <= m_idx;
        pend_dat <= int'(wdata);
        if (rst)         m_idx <= 0;
        else if (idx_wr) m_idx <= int'(wdata[4:0]);
    end

    // measurement tallies
    bit meas_en = 1'b0;
    int t_maxcol, t_maxrow, t_hs_act, t_vs_act, t_hs_low, t_vs_low, t_blank, t_de, t_row3;

    always @(negedge clk) begin
        if (rst_p) begin
            foreach (m_regs[i]) m_regs[i] = 8'h00;
            m_col = 0; m_row = 0; m_hs = 0; m_hb = 0; m_vs = 0; m_vb = 0;
            m_ph = 0; m_rise = 0; m_start = 0;
        end else begin
            int  ncol, nrow, lim;
            bit  le, adv, nhs, nhb, nvs, nvb;
            lim  = int'(m_regs[0]) + 4;
            le   = (m_col >= lim);
            ncol = le ? 0 : m_col + 1;
            nhs  = m_hs ? ((ncol % 32) != int'(m_regs[5][4:0])) : (ncol == int'(m_regs[4]));
            nhb  = m_hb ? ((ncol % 32) != int'(m_regs[3][4:0])) : (ncol == int'(m_regs[2]));
            adv  = 1'b0;
            if (le) begin
                if (m_regs[13][7] && !m_ph) m_ph = 1'b1;
                else begin m_ph = 1'b0; adv = 1'b1; end
            end
            nrow = m_row; nvs = m_vs; nvb = m_vb;
            if (adv) begin
                nrow = (m_row >= f_vtot() + 1) ? 0 : m_row + 1;
                nvs  = m_vs ? ((nrow % 16) != int'(m_regs[12][3:0])) : (nrow == f_vss());
                nvb  = m_vb ? ((nrow % 256) != int'(m_regs[10])) : (nrow == f_vbs());
            end
            if (m_rise) m_start = {16'd0, m_regs[14], m_regs[15]};
            m_rise = !m_vs && nvs;
            m_col = ncol; m_row = nrow; m_hs = nhs; m_hb = nhb; m_vs = nvs; m_vb = nvb;
            if (pend_v && pend_idx < 18 && !(pend_idx < 8 && m_regs[12][7]))
                m_regs[pend_idx] = pend_dat[7:0];

            chk(int'(col_o) == m_col, "R2 column count", col_o, m_col);
            chk(int'(row_o) == m_row, "R3 row count", row_o, m_row);
            chk(hsync_o == (m_hs ^ m_regs[17][0]), "R4/R8 hsync", hsync_o, m_hs ^ m_regs[17][0]);
            chk(vsync_o == (m_vs ^ m_regs[17][1]), "R5/R8 vsync", vsync_o, m_vs ^ m_regs[17][1]);
            chk(blank_o == (m_hb | m_vb), "R6 blank", blank_o, m_hb | m_vb);
            chk(de_o == ((m_col <= int'(m_regs[1])) && (m_row <= f_vde())), "R6 display enable",
                de_o, (m_col <= int'(m_regs[1])) && (m_row <= f_vde()));
            chk(int'(start_addr_o) == m_start, "R10 start address", start_addr_o, m_start);
            chk(row_offset_o == m_regs[16], "R10 row offset", row_offset_o, m_regs[16]);
        end

        if (!meas_en) begin
            t_maxcol = 0; t_maxrow = 0; t_hs_act = 0; t_vs_act = 0; t_hs_low = 0;
            t_vs_low = 0; t_blank = 0; t_de = 0; t_row3 = 0;
        end else begin
            if (int'(col_o) > t_maxcol) t_maxcol = int'(col_o);
            if (int'(row_o) > t_maxrow) t_maxrow = int'(row_o);
            if (hsync_o != m_regs[17][0]) t_hs_act++;
            if (vsync_o != m_regs[17][1]) t_vs_act++;
            if (!hsync_o) t_hs_low++;
            if (!vsync_o) t_vs_low++;
            if (blank_o) t_blank++;
            if (de_o) t_de++;
            if (row_o == 10'd3) t_row3++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr_reg(input int idx, input int val);
        @(negedge clk); idx_wr = 1'b1; wdata = idx[7:0];
        @(negedge clk); idx_wr = 1'b0; dat_wr = 1'b1; wdata = val[7:0];
        @(negedge clk); dat_wr = 1'b0; wdata = 8'h00;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic window(input int n);
        @(posedge clk); #1 meas_en = 1'b1;
        repeat (n) @(posedge clk);
        #1 meas_en = 1'b0;
    endtask

    task automatic program_base();
        wr_reg(12, 10);   // vsync end 10, protect off
        wr_reg(0, 11);    // 16 characters per line
        wr_reg(1, 9);
        wr_reg(2, 10);
        wr_reg(3, 15);
        wr_reg(4, 11);
        wr_reg(5, 13);
        wr_reg(6, 10);    // 12 lines per frame
        wr_reg(7, 0);
        wr_reg(8, 7);
        wr_reg(9, 8);
        wr_reg(10, 11);
        wr_reg(11, 9);
        wr_reg(13, 0);
        wr_reg(17, 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        int unused;
        unused = $urandom(32'd4711);
        repeat (4) @(negedge clk);
        // R1: reset state observed while reset is held
        chk(col_o == 9'd0 && row_o == 10'd0, "R1 reset counters", {col_o, row_o}, 0);
        chk(!hsync_o && !vsync_o && !blank_o, "R1 reset sync/blank", {hsync_o, vsync_o, blank_o}, 0);
        chk(de_o == 1'b1, "R1 reset display enable", de_o, 1);
        chk(start_addr_o == 16'd0 && row_offset_o == 8'd0, "R1 reset address", start_addr_o, 0);
        rst = 1'b0;

        // R12 baseline programming through the index/data port
        program_base();
        run(400);
        window(192);
        chk(t_maxcol == 15, "R2 line length", t_maxcol, 15);
        chk(t_maxrow == 11, "R3 frame length", t_maxrow, 11);
        chk(t_hs_act == 24, "R4 hsync width per frame", t_hs_act, 24);
        chk(t_vs_act == 16, "R5 vsync width per frame", t_vs_act, 16);
        chk(t_blank == 93, "R6 blank cycles per frame", t_blank, 93);
        chk(t_de == 80, "R6 display cycles per frame", t_de, 80);

        // R8 inverted polarity
        wr_reg(17, 3);
        run(200);
        window(192);
        chk(t_hs_low == 24, "R8 active-low hsync", t_hs_low, 24);
        chk(t_vs_low == 16, "R8 active-low vsync", t_vs_low, 16);
        wr_reg(17, 0);

        // R10 start address only moves after vsync onset
        wr_reg(14, 8'h12);
        wr_reg(15, 8'h34);
        chk(start_addr_o == 16'h0000 || row_o == 10'd9, "R10 start held before vsync",
            start_addr_o, 0);
        run(200);
        chk(start_addr_o == 16'h1234, "R10 start after vsync", start_addr_o, 16'h1234);
        wr_reg(16, 8'h55);
        @(negedge clk);
        chk(row_offset_o == 8'h55, "R10 row offset", row_offset_o, 8'h55);

        // R12 index beyond the bank changes nothing visible
        wr_reg(20, 8'hAA);
        run(200);
        window(192);
        chk(row_offset_o == 8'h55, "R12 out-of-range index offset", row_offset_o, 8'h55);
        chk(t_hs_act == 24 && t_maxcol == 15, "R12 out-of-range index timing", t_hs_act, 24);

        // R9 protection of the low registers
        wr_reg(12, 8'h80 | 10);
        wr_reg(0, 3);
        wr_reg(4, 2);
        run(200);
        window(192);
        chk(t_maxcol == 15, "R9 protected total", t_maxcol, 15);
        chk(t_hs_act == 24, "R9 protected sync start", t_hs_act, 24);
        wr_reg(12, 10);

        // R11 unreachable sync starts
        wr_reg(4, 8'hFF);
        wr_reg(5, 0);
        wr_reg(11, 8'hFF);
        run(400);
        window(384);
        chk(t_hs_act == 0, "R11 hsync suppressed", t_hs_act, 0);
        chk(t_vs_act == 0, "R11 vsync suppressed", t_vs_act, 0);
        wr_reg(4, 11);
        wr_reg(5, 13);
        wr_reg(11, 9);

        // R7 double scan
        wr_reg(13, 8'h80);
        run(800);
        window(768);
        chk(t_row3 == 64, "R7 double scan row hold", t_row3, 64);
        chk(t_maxrow == 11, "R7 double scan row range", t_maxrow, 11);
        wr_reg(13, 0);

        // R3 ten-bit vertical total through the overflow register
        wr_reg(0, 3);
        wr_reg(6, 0);
        wr_reg(7, 8'h01);
        run(2100);
        window(2064);
        chk(t_maxrow == 257, "R3 overflow total", t_maxrow, 257);
        chk(t_row3 == 8, "R3 overflow line length", t_row3, 8);
        program_base();
        run(200);

        // constrained random timings against the model
        for (int it = 0; it < 15; it++) begin
            int ht, vt, len;
            ht = 2 + int'($urandom % 28);
            vt = 2 + int'($urandom % 18);
            wr_reg(12, (($urandom % 4) == 0 ? 8'h80 : 8'h00) | int'($urandom % 16));
            wr_reg(0, ht);
            wr_reg(1, int'($urandom % (ht + 6)));
            wr_reg(2, int'($urandom % (ht + 6)));
            wr_reg(3, int'($urandom % 32));
            wr_reg(4, int'($urandom % (ht + 6)));
            wr_reg(5, int'($urandom % 32));
            wr_reg(6, vt);
            wr_reg(7, 0);
            wr_reg(8, int'($urandom % (vt + 4)));
            wr_reg(9, int'($urandom % (vt + 4)));
            wr_reg(10, int'($urandom % (vt + 4)));
            wr_reg(11, int'($urandom % (vt + 4)));
            wr_reg(13, ($urandom % 2) == 0 ? 8'h80 : 8'h00);
            wr_reg(14, int'($urandom % 256));
            wr_reg(15, int'($urandom % 256));
            wr_reg(16, int'($urandom % 256));
            wr_reg(17, int'($urandom % 4));
            len = (int'(m_regs[0]) + 5) * (f_vtot() + 2) * 2 * (m_regs[13][7] ? 2 : 1) + 20;
            if (len > 12000) len = 12000;
            run(len);
            chk(1'b1, "R4/R5 random timing set", it, it);
        end
        wr_reg(12, 10);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule